// File: doc/BRIEF.md
# Host Command Checksum Handshake Engine

This block sits on the device side of a byte link from a host controller and receives the host's short command frames. A header byte opens each frame. Its bit 2 must be set. Its bit 0 selects a two-byte standard frame (header plus code) or a four-byte extended frame (header, code, data, command). Its bit 1 marks the code byte as a function or an address. Its bits 7..3 carry a dim count. Two further single-byte values act as control commands that switch a ring-enable flag on or off. The engine adds up every byte of a frame and returns the 8-bit sum, so the host can confirm the frame before anything acts on it.

When the host answers the sum with an acknowledge byte of 0x00, the engine carries out the frame. For a header-led frame it raises a one-cycle transmit request with the decoded fields and waits for a transmit-done input from the line driver. For a control command it updates the ring flag. It then returns the ready byte 0x55. If the host disagrees with the sum, it simply sends the whole frame again. Any new header seen while the engine waits for the acknowledge throws away the pending frame. If no acknowledge arrives within a parameterised number of cycles, the engine abandons the frame.

Both byte streams use valid/ready handshakes. A byte moves on a rising clock edge at which valid and ready are both high.

Top module: `hcmd_engine`

## Requirements
- R1: While reset is held and just after it is released, `out_valid` and `xmit_req` are 0, `in_ready` is 1 and `ring_en` is 1.
- R2: In the idle state, a received byte with bit 2 clear that is neither 0xEB nor 0xDB starts nothing. No reply byte and no transmit request follow.
- R3: A header with bit 2 set and bit 0 clear opens a two-byte frame. After the second byte the engine offers one reply byte equal to the sum of both bytes modulo 256 (for example, 0x04 then 0x66 gives 0x6A).
- R4: A header with bit 2 set and bit 0 set opens a four-byte frame. The reply is the sum of all four bytes modulo 256 (for example, 0x07, 0xA7, 0xFF, 0x55 gives 0x02).
- R5: An acknowledge byte 0x00 received after the sum of a header-led frame produces one transmit request. With the request come: `xmit_dim` = header bits 7..3; `xmit_func` = header bit 1; `xmit_ext` = header bit 0; `xmit_house` = code bits 7..4; `xmit_unit` = code bits 3..0; `xmit_data` and `xmit_cmd` = the third and fourth bytes. For a two-byte frame, `xmit_data` and `xmit_cmd` are 0.
- R6: After a transmit request the engine takes no bytes and offers none until `xmit_done` is high on a clock edge. It then offers the ready byte 0x55.
- R7: A header byte (bit 2 set) arriving in place of the acknowledge discards the pending frame and starts a new one. The discarded frame never produces a transmit request.
- R8: The byte 0xDB returns 0xDB as its sum and, once acknowledged, clears `ring_en`. The byte 0xEB returns 0xEB and, once acknowledged, sets `ring_en`. Neither raises `xmit_req`; both end with 0x55.
- R9: If no byte is accepted for `ACK_TIMEOUT` cycles after the sum has been taken, the engine returns to idle. A later 0x00 then has no effect.
- R10: While the engine waits for the acknowledge, a byte with bit 2 clear other than 0x00, 0xEB and 0xDB is taken and ignored. The engine keeps waiting, and a following 0x00 still executes the frame.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R12: `xmit_req` is high for exactly one cycle per acknowledged header-led frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Byte from the host |
| in_valid | input | 1 | Host byte present |
| in_ready | output | 1 | Engine can take a host byte |
| out_data | output | 8 | Reply byte (sum, echo or ready code) |
| out_valid | output | 1 | Reply byte present |
| out_ready | input | 1 | Host side takes the reply byte |
| xmit_req | output | 1 | One-cycle request to send the decoded frame |
| xmit_dim | output | 5 | Dim count from the header |
| xmit_func | output | 1 | Code byte is a function (1) or an address (0) |
| xmit_ext | output | 1 | Frame is extended |
| xmit_house | output | 4 | High nibble of the code byte |
| xmit_unit | output | 4 | Low nibble of the code byte |
| xmit_data | output | 8 | Third frame byte, 0 for short frames |
| xmit_cmd | output | 8 | Fourth frame byte, 0 for short frames |
| xmit_done | input | 1 | Line driver finished the request |
| ring_en | output | 1 | Ring-enable flag |

## Verification
The hardest state to reach is the wait for the acknowledge, because several outcomes compete there: a fresh header, a stray byte, the acknowledge itself, and the timeout. To test it, the bench stops after a sum has been delivered. It then sends each competing input in turn: a second header to replace the frame, a byte with bit 2 clear that must be ignored, and a long idle gap longer than the timeout. After each one it checks whether a transmit request and a ready byte follow. Back-pressure on the reply stream is added by holding `out_ready` low while a sum is on offer.

// File: rtl/hcmd_pkg.sv
package hcmd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_COLLECT,
      ST_SUM,
      ST_WAIT_ACK,
      ST_WAIT_DONE,
      ST_READY
   } hcmd_state_e;

   typedef enum logic [2:0] {
      K_NONE,
      K_STD,
      K_EXT,
      K_RING_ON,
      K_RING_OFF
   } hcmd_kind_e;

endpackage

// File: rtl/hcmd_classify.sv
module hcmd_classify
   import hcmd_pkg::*;
#(
   parameter int                BYTE_W        = 8,
   parameter int                SYNC_BIT      = 2,
   parameter int                EXT_BIT       = 0,
   parameter logic [BYTE_W-1:0] RING_ON_CODE  = 8'hEB,
   parameter logic [BYTE_W-1:0] RING_OFF_CODE = 8'hDB
) (
   input  logic [BYTE_W-1:0] byte_i,
   output hcmd_kind_e        kind_o
);

   always_comb begin
      if (byte_i == RING_ON_CODE) begin
         kind_o = K_RING_ON;
      end else if (byte_i == RING_OFF_CODE) begin
         kind_o = K_RING_OFF;
      end else if (!byte_i[SYNC_BIT]) begin
         kind_o = K_NONE;
      end else if (byte_i[EXT_BIT]) begin
         kind_o = K_EXT;
      end else begin
         kind_o = K_STD;
      end
   end

endmodule

// File: rtl/hcmd_frame_store.sv
module hcmd_frame_store #(
   parameter  int BYTE_W       = 8,
   parameter  int SLOTS        = 4,
   parameter  bit CLEAR_UNUSED = 1'b1,
   localparam int IDX_W        = $clog2(SLOTS + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic                         take_i,
   input  logic [BYTE_W-1:0]            byte_i,
   output logic [SLOTS-1:0][BYTE_W-1:0] slot_o,
   output logic [BYTE_W-1:0]            sum_o,
   output logic [IDX_W-1:0]             fill_o
);

   logic [BYTE_W-1:0] sum_q;
   logic [IDX_W-1:0]  fill_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q  <= '0;
         fill_q <= '0;
      end else if (start_i) begin
         sum_q  <= byte_i;
         fill_q <= IDX_W'(1);
      end else if (take_i) begin
         sum_q  <= sum_q + byte_i;
         fill_q <= fill_q + 1'b1;
      end
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [BYTE_W-1:0] q;
      if (s == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q <= '0;
            else if (start_i) q <= byte_i;
         end
      end else if (CLEAR_UNUSED) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  q <= '0;
            else if (start_i)                            q <= '0;
            else if (take_i && fill_q == IDX_W'(s))      q <= byte_i;
         end
      end else begin : g_keep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  q <= '0;
            else if (take_i && fill_q == IDX_W'(s))      q <= byte_i;
         end
      end
      assign slot_o[s] = q;
   end

   assign sum_o  = sum_q;
   assign fill_o = fill_q;

endmodule

// File: rtl/hcmd_ack_timer.sv
module hcmd_ack_timer #(
   parameter  int LIMIT = 64,
   localparam int CNT_W = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expired_o
);

   logic [CNT_W-1:0] cnt_q;

   assign expired_o = (cnt_q == CNT_W'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!run_i)     cnt_q <= '0;
      else if (!expired_o) cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/hcmd_engine.sv
module hcmd_engine
   import hcmd_pkg::*;
#(
   parameter  int                BYTE_W        = 8,
   parameter  int                SYNC_BIT      = 2,
   parameter  int                FUNC_BIT      = 1,
   parameter  int                EXT_BIT       = 0,
   parameter  int                STD_LEN       = 2,
   parameter  int                EXT_LEN       = 4,
   parameter  int                ACK_TIMEOUT   = 64,
   parameter  logic [BYTE_W-1:0] ACK_CODE      = 8'h00,
   parameter  logic [BYTE_W-1:0] READY_CODE    = 8'h55,
   parameter  logic [BYTE_W-1:0] RING_ON_CODE  = 8'hEB,
   parameter  logic [BYTE_W-1:0] RING_OFF_CODE = 8'hDB,
   parameter  bit                CLEAR_UNUSED  = 1'b1,
   localparam int                DIM_W         = BYTE_W - SYNC_BIT - 1,
   localparam int                NIB_W         = BYTE_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              xmit_req,
   output logic [DIM_W-1:0]  xmit_dim,
   output logic              xmit_func,
   output logic              xmit_ext,
   output logic [NIB_W-1:0]  xmit_house,
   output logic [NIB_W-1:0]  xmit_unit,
   output logic [BYTE_W-1:0] xmit_data,
   output logic [BYTE_W-1:0] xmit_cmd,
   input  logic              xmit_done,
   output logic              ring_en
);

   localparam int IDX_W = $clog2(EXT_LEN + 1);

   // elaboration-time parameter checks
   if (BYTE_W < 8 || (BYTE_W % 2) != 0) begin : g_bad_width
      $error("hcmd_engine: BYTE_W must be even and at least 8");
   end
   if (STD_LEN != 2 || EXT_LEN < STD_LEN + 2) begin : g_bad_len
      $error("hcmd_engine: frame lengths must be 2 and at least 4");
   end
   if (ACK_TIMEOUT < 2) begin : g_bad_timeout
      $error("hcmd_engine: ACK_TIMEOUT must be at least 2");
   end
   if (ACK_CODE[SYNC_BIT]) begin : g_bad_ack
      $error("hcmd_engine: acknowledge code must have the sync bit clear");
   end
   if (SYNC_BIT <= FUNC_BIT || FUNC_BIT == EXT_BIT) begin : g_bad_bits
      $error("hcmd_engine: header bit positions overlap");
   end

   hcmd_state_e st_q, st_d;
   hcmd_kind_e  kind_q, kind_d, in_kind;
   logic [IDX_W-1:0] need_q, need_d;
   logic             req_q, req_d;
   logic             ring_q, ring_d;
   logic             start, take, accept, expired;
   logic [EXT_LEN-1:0][BYTE_W-1:0] slot;
   logic [BYTE_W-1:0]              sum;
   logic [IDX_W-1:0]               fill;

   hcmd_classify #(
      .BYTE_W       (BYTE_W),
      .SYNC_BIT     (SYNC_BIT),
      .EXT_BIT      (EXT_BIT),
      .RING_ON_CODE (RING_ON_CODE),
      .RING_OFF_CODE(RING_OFF_CODE)
   ) u_classify (
      .byte_i(in_data),
      .kind_o(in_kind)
   );

   hcmd_frame_store #(
      .BYTE_W      (BYTE_W),
      .SLOTS       (EXT_LEN),
      .CLEAR_UNUSED(CLEAR_UNUSED)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start),
      .take_i (take),
      .byte_i (in_data),
      .slot_o (slot),
      .sum_o  (sum),
      .fill_o (fill)
   );

   hcmd_ack_timer #(
      .LIMIT(ACK_TIMEOUT)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (st_q == ST_WAIT_ACK),
      .expired_o(expired)
   );

   assign in_ready  = (st_q == ST_IDLE) || (st_q == ST_COLLECT) || (st_q == ST_WAIT_ACK);
   assign accept    = in_valid && in_ready;
   assign out_valid = (st_q == ST_SUM) || (st_q == ST_READY);
   assign out_data  = (st_q == ST_READY) ? READY_CODE : sum;

   always_comb begin
      st_d   = st_q;
      kind_d = kind_q;
      need_d = need_q;
      req_d  = 1'b0;
      ring_d = ring_q;
      start  = 1'b0;
      take   = 1'b0;
      unique case (st_q)
         ST_IDLE, ST_WAIT_ACK: begin
            if (accept) begin
               if (st_q == ST_WAIT_ACK && in_data == ACK_CODE) begin
                  if (kind_q == K_RING_ON || kind_q == K_RING_OFF) begin
                     ring_d = (kind_q == K_RING_ON);
                     st_d   = ST_READY;
                  end else begin
                     req_d = 1'b1;
                     st_d  = ST_WAIT_DONE;
                  end
               end else begin
                  unique case (in_kind)
                     K_STD: begin
                        start  = 1'b1;
                        kind_d = K_STD;
                        need_d = IDX_W'(STD_LEN);
                        st_d   = ST_COLLECT;
                     end
                     K_EXT: begin
                        start  = 1'b1;
                        kind_d = K_EXT;
                        need_d = IDX_W'(EXT_LEN);
                        st_d   = ST_COLLECT;
                     end
                     K_RING_ON, K_RING_OFF: begin
                        start  = 1'b1;
                        kind_d = in_kind;
                        st_d   = ST_SUM;
                     end
                     default: ;
                  endcase
               end
            end else if (st_q == ST_WAIT_ACK && expired) begin
               st_d = ST_IDLE;
            end
         end
         ST_COLLECT: begin
            if (accept) begin
               take = 1'b1;
               if ((fill + 1'b1) == need_q) st_d = ST_SUM;
            end
         end
         ST_SUM: begin
            if (out_ready) st_d = ST_WAIT_ACK;
         end
         ST_WAIT_DONE: begin
            if (xmit_done) st_d = ST_READY;
         end
         ST_READY: begin
            if (out_ready) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         kind_q <= K_NONE;
         need_q <= '0;
         req_q  <= 1'b0;
         ring_q <= 1'b1;
      end else begin
         st_q   <= st_d;
         kind_q <= kind_d;
         need_q <= need_d;
         req_q  <= req_d;
         ring_q <= ring_d;
      end
   end

   assign xmit_req   = req_q;
   assign ring_en    = ring_q;
   assign xmit_dim   = slot[0][BYTE_W-1:SYNC_BIT+1];
   assign xmit_func  = slot[0][FUNC_BIT];
   assign xmit_ext   = slot[0][EXT_BIT];
   assign xmit_house = slot[1][BYTE_W-1:NIB_W];
   assign xmit_unit  = slot[1][NIB_W-1:0];
   assign xmit_data  = slot[EXT_LEN-2];
   assign xmit_cmd   = slot[EXT_LEN-1];

   logic unused_hdr;
   assign unused_hdr = slot[0][SYNC_BIT];

endmodule

// File: rtl/hcmd_engine_chk.sv
module hcmd_engine_chk #(
   parameter int                BYTE_W   = 8,
   parameter logic [BYTE_W-1:0] ACK_CODE = 8'h00
) (
   input logic              clk,
   input logic              rst_n,
   input logic [BYTE_W-1:0] in_data,
   input logic              in_valid,
   input logic              in_ready,
   input logic [BYTE_W-1:0] out_data,
   input logic              out_valid,
   input logic              out_ready,
   input logic              xmit_req,
   input logic              ring_en
);

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      xmit_req |=> !xmit_req);

   p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      xmit_req |-> !out_valid && !in_ready);

   p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   p_ring_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_en != $past(ring_en)) |-> $past(in_valid && in_ready && in_data == ACK_CODE));

   p_ring_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_en != $past(ring_en)) |-> !xmit_req);

endmodule

bind hcmd_engine hcmd_engine_chk #(
   .BYTE_W  (BYTE_W),
   .ACK_CODE(ACK_CODE)
) u_chk (.*);

// File: tb/hcmd_engine_test.sv
module hcmd_engine_test;

   localparam int CLK_PERIOD = 10;
   localparam int TMO        = 20;
   localparam int DONE_LAT   = 4;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] in_data = '0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] out_data;
   logic       out_valid;
   logic       out_ready = 1'b1;
   logic       xmit_req;
   logic [4:0] xmit_dim;
   logic       xmit_func;
   logic       xmit_ext;
   logic [3:0] xmit_house;
   logic [3:0] xmit_unit;
   logic [7:0] xmit_data;
   logic [7:0] xmit_cmd;
   logic       xmit_done = 1'b0;
   logic       ring_en;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   int exp_pulses = 0;

   logic [7:0]  exp_out_q[$];
   string       exp_tag_q[$];
   logic [30:0] exp_x_q[$];

   hcmd_engine #(.ACK_TIMEOUT(TMO)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_data   (in_data),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .out_data  (out_data),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .xmit_req  (xmit_req),
      .xmit_dim  (xmit_dim),
      .xmit_func (xmit_func),
      .xmit_ext  (xmit_ext),
      .xmit_house(xmit_house),
      .xmit_unit (xmit_unit),
      .xmit_data (xmit_data),
      .xmit_cmd  (xmit_cmd),
      .xmit_done (xmit_done),
      .ring_en   (ring_en)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [30:0] rec(input logic [4:0] dim, input logic f, input logic e,
                                       input logic [7:0] code, input logic [7:0] d,
                                       input logic [7:0] c);
      return {dim, f, e, code, d, c};
   endfunction

   // scoreboard monitor: reply bytes and transmit requests
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid && out_ready) begin
            if (exp_out_q.size() == 0) begin
               check(1'b0, "R3", "unexpected reply byte", {24'h0, out_data}, 32'h0);
            end else begin
               logic [7:0] e;
               string      t;
               e = exp_out_q.pop_front();
               t = exp_tag_q.pop_front();
               check(out_data == e, t, "reply byte", {24'h0, out_data}, {24'h0, e});
            end
         end
         if (xmit_req) begin
            logic [30:0] got;
            pulses++;
            got = {xmit_dim, xmit_func, xmit_ext, xmit_house, xmit_unit, xmit_data, xmit_cmd};
            if (exp_x_q.size() == 0) begin
               check(1'b0, "R5", "unexpected transmit request", {1'b0, got}, 32'h0);
            end else begin
               logic [30:0] ex;
               ex = exp_x_q.pop_front();
               check(got == ex, "R5", "transmit fields", {1'b0, got}, {1'b0, ex});
            end
         end
      end
   end

   // line driver model: answers each request after DONE_LAT cycles
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && xmit_req) begin
            for (int k = 0; k < DONE_LAT; k++) begin
               @(negedge clk);
               check(!out_valid && !in_ready && !xmit_req, "R6", "busy while transmitting",
                     {29'h0, out_valid, in_ready, xmit_req}, 32'h0);
            end
            xmit_done = 1'b1;
            @(negedge clk);
            xmit_done = 1'b0;
         end
      end
   end

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      in_data  = b;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   task automatic frame2(input logic [7:0] h, input logic [7:0] c, input string tag);
      exp_out_q.push_back(h + c);
      exp_tag_q.push_back(tag);
      send(h);
      send(c);
   endtask

   task automatic frame4(input logic [7:0] h, input logic [7:0] c, input logic [7:0] d,
                         input logic [7:0] m);
      exp_out_q.push_back(h + c + d + m);
      exp_tag_q.push_back("R4");
      send(h);
      send(c);
      send(d);
      send(m);
   endtask

   task automatic ack_x(input logic [30:0] r);
      exp_x_q.push_back(r);
      exp_pulses++;
      exp_out_q.push_back(8'h55);
      exp_tag_q.push_back("R6");
      send(8'h00);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b1;
      #1 rst_n = 1'b0;
      idle(3);
      check(!out_valid && !xmit_req && in_ready && ring_en, "R1", "state during reset",
            {28'h0, out_valid, xmit_req, in_ready, ring_en}, 32'h3);
      rst_n = 1'b1;
      idle(2);
      check(!out_valid && !xmit_req && in_ready && ring_en, "R1", "state after reset",
            {28'h0, out_valid, xmit_req, in_ready, ring_en}, 32'h3);

      // R2: bytes without the sync bit are not headers
      send(8'h00);
      send(8'h3A);
      send(8'hC3);
      idle(6);
      check(!out_valid && pulses == 0, "R2", "no reply to non-header bytes",
            {31'h0, out_valid}, 32'h0);

      // R3 / R5: address A1, then function with dim count 16
      frame2(8'h04, 8'h66, "R3");
      ack_x(rec(5'd0, 1'b0, 1'b0, 8'h66, 8'h00, 8'h00));
      idle(4);
      frame2(8'h86, 8'h64, "R3");
      ack_x(rec(5'd16, 1'b1, 1'b0, 8'h64, 8'h00, 8'h00));
      idle(4);

      // R4: extended frame
      frame4(8'h07, 8'hA7, 8'hFF, 8'h55);
      ack_x(rec(5'd0, 1'b1, 1'b1, 8'hA7, 8'hFF, 8'h55));
      idle(4);
      // R5: short frame after an extended one reports zero data and command
      frame2(8'h06, 8'h6E, "R3");
      ack_x(rec(5'd0, 1'b1, 1'b0, 8'h6E, 8'h00, 8'h00));
      idle(4);

      // R7: replacement header discards the pending frame
      frame2(8'h86, 8'h64, "R7");
      frame2(8'h04, 8'h6E, "R7");
      ack_x(rec(5'd0, 1'b0, 1'b0, 8'h6E, 8'h00, 8'h00));
      idle(4);

      // R10: stray byte while waiting for the acknowledge
      frame2(8'h04, 8'h66, "R3");
      send(8'h11);
      idle(3);
      check(in_ready && !out_valid && !xmit_req, "R10", "still waiting after stray byte",
            {29'h0, in_ready, out_valid, xmit_req}, 32'h4);
      ack_x(rec(5'd0, 1'b0, 1'b0, 8'h66, 8'h00, 8'h00));
      idle(4);

      // R8: ring disable then enable
      exp_out_q.push_back(8'hDB);
      exp_tag_q.push_back("R8");
      send(8'hDB);
      exp_out_q.push_back(8'h55);
      exp_tag_q.push_back("R8");
      send(8'h00);
      idle(3);
      check(ring_en == 1'b0, "R8", "ring flag after disable", {31'h0, ring_en}, 32'h0);
      exp_out_q.push_back(8'hEB);
      exp_tag_q.push_back("R8");
      send(8'hEB);
      exp_out_q.push_back(8'h55);
      exp_tag_q.push_back("R8");
      send(8'h00);
      idle(3);
      check(ring_en == 1'b1, "R8", "ring flag after enable", {31'h0, ring_en}, 32'h1);
      check(pulses == exp_pulses, "R8", "no transmit for ring commands", pulses, exp_pulses);

      // R9: acknowledge too late
      frame2(8'h04, 8'h66, "R9");
      idle(TMO + 4);
      send(8'h00);
      idle(12);
      check(pulses == exp_pulses, "R9", "late acknowledge ignored", pulses, exp_pulses);
      check(!out_valid, "R9", "no ready byte after timeout", {31'h0, out_valid}, 32'h0);

      // R11: back-pressure on the reply
      out_ready = 1'b0;
      frame2(8'h04, 8'h6E, "R11");
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
         check(out_valid && out_data == 8'h72, "R11", "reply held under back-pressure",
               {23'h0, out_valid, out_data}, 32'h172);
         @(negedge clk);
      end
      out_ready = 1'b1;
      ack_x(rec(5'd0, 1'b0, 1'b0, 8'h6E, 8'h00, 8'h00));
      idle(12);

      check(exp_out_q.size() == 0, "R3", "all expected replies seen", exp_out_q.size(), 0);
      check(exp_x_q.size() == 0, "R5", "all expected requests seen", exp_x_q.size(), 0);
      check(pulses == exp_pulses, "R12", "one request per acknowledged frame",
            pulses, exp_pulses);
      finish_run();
   end

endmodule